// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between a software register port and a slow, frame-based serial link to an external audio codec. Software posts one command at a time: a register address, write data and a direction flag (read or write). Posting a command raises a command-pending flag. The controller places the command into the outgoing command slot at the next frame boundary and drops the pending flag on that same boundary. Software may then post the next command.

For a read, the codec answers in the frame that follows the one that carried the command. The controller compares the returned address with the address of the read it expects in that frame. On a match it loads a status register with the address and data and raises a status-new flag. Software clears that flag with a status-read strobe. The pending flag drops before the result of the same read arrives, so a second read can be posted while the first result is still on its way. The response tracker therefore follows two reads at once: one whose command is on the link, and one whose answer is due.

The command side is a two-state machine. In CMD_IDLE, a posted command moves it to CMD_ARMED. In CMD_ARMED, a frame boundary moves it back to CMD_IDLE. The response side is a four-state machine: RSP_IDLE, RSP_INFLIGHT, RSP_DUE and RSP_DUE_INFLIGHT. At every frame boundary a read in flight becomes due, and a read picked up on that boundary becomes the new read in flight. An answer that is not matched by the end of its frame is dropped. A matching answer moves RSP_DUE to RSP_IDLE, or RSP_DUE_INFLIGHT to RSP_INFLIGHT.

Top module: `codec_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_new`, `cmd_overrun`, `stat_new` and `tx_valid` are all 0.
- R2: A `sw_cmd_wr` pulse while `cmd_new` is 0 captures address, data and direction (`sw_cmd_rd`=1 means read, 0 means write), and `cmd_new` reads 1 from the next cycle.
- R3: On a `frame_start` cycle with `cmd_new` set, `cmd_new` clears and the command slot shows `tx_valid`=1 with the captured `tx_addr`, `tx_data` and `tx_rd`. The slot holds these values until the next `frame_start`, where it reloads or goes invalid.
- R4: A write command never causes `stat_new` to be set.
- R5: For a read sent in frame N, an `rx_valid` pulse in frame N+1 whose `rx_addr` equals the read address loads `stat_addr`/`stat_data` and sets `stat_new` on the following cycle.
- R6: A returned word whose address differs from the due read's address is ignored, and `stat_new` stays 0.
- R7: `cmd_new` clears before `stat_new` is set for the same read. A second read posted before the first result arrives is still sent, and both results are delivered in order.
- R8: A `sw_stat_rd` pulse clears `stat_new` on the next cycle. If a matching answer arrives in the same cycle, the load wins: `stat_new` stays 1 with the new data.
- R9: A `sw_cmd_wr` while `cmd_new` is 1 is ignored, so the earlier command is the one sent. It also sets the sticky `cmd_overrun`, which stays 1 until reset.
- R10: An `rx_valid` in a `frame_start` cycle is ignored. The answer that was due is then lost, and `stat_new` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_cmd_wr | input | 1 | Software command write strobe |
| sw_cmd_rd | input | 1 | Direction of posted command, 1 = read |
| sw_cmd_addr | input | ADDR_W | Codec register address |
| sw_cmd_data | input | DATA_W | Write data (unused for reads) |
| sw_stat_rd | input | 1 | Software status read strobe, clears stat_new |
| cmd_new | output | 1 | Command pending, not yet taken by the link |
| cmd_overrun | output | 1 | Sticky: a command was posted while one was pending |
| stat_new | output | 1 | Status register holds unread read data |
| stat_addr | output | ADDR_W | Address of the returned read data |
| stat_data | output | DATA_W | Returned read data |
| frame_start | input | 1 | One-cycle pulse at each link frame boundary |
| tx_valid | output | 1 | Command slot carries a command this frame |
| tx_rd | output | 1 | Command slot direction, 1 = read |
| tx_addr | output | ADDR_W | Command slot address |
| tx_data | output | DATA_W | Command slot write data |
| rx_valid | input | 1 | Returned read word present this cycle |
| rx_addr | input | ADDR_W | Address tag of the returned word |
| rx_data | input | DATA_W | Returned read data |

## Verification
The hardest state to reach from the ports is RSP_DUE_INFLIGHT. It needs a second read to be posted in the short window after the first read's `cmd_new` drops and before its answer comes back. The bench gets there by posting the second read at once in the cycle that `cmd_new` falls. A behavioural codec model that answers one frame later checks that both results come back in order. A second hard case is a status-read strobe in the same cycle as a matching answer. The bench builds it by waiting for the model to raise `rx_valid` and asserting `sw_stat_rd` before the next clock edge.

// File: rtl/codec_cmd_pkg.sv
package codec_cmd_pkg;

    typedef enum logic [0:0] {
        CMD_IDLE,
        CMD_ARMED
    } cmd_state_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_INFLIGHT,
        RSP_DUE,
        RSP_DUE_INFLIGHT
    } rsp_state_t;

endpackage

// File: rtl/codec_cmd_slot.sv
module codec_cmd_slot
    import codec_cmd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_cmd,
    input  logic              wr_rd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_pending,
    output logic              overrun,
    output logic              tx_valid,
    output logic              tx_rd,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data,
    output logic              take_rd,
    output logic [ADDR_W-1:0] take_addr
);

    cmd_state_t        state, nxt;
    logic              accept, take, reject;
    logic              hold_rd;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CMD_IDLE:  if (wr_cmd)      nxt = CMD_ARMED;
            CMD_ARMED: if (frame_start) nxt = CMD_IDLE;
        endcase
    end

    always_comb begin
        cmd_pending = (state == CMD_ARMED);
        accept      = (state == CMD_IDLE)  && wr_cmd;
        take        = (state == CMD_ARMED) && frame_start;
        reject      = (state == CMD_ARMED) && wr_cmd;
        take_rd     = take && hold_rd;
        take_addr   = hold_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rd   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (accept) begin
            hold_rd   <= wr_rd;
            hold_addr <= wr_addr;
            hold_data <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_rd    <= 1'b0;
            tx_addr  <= '0;
            tx_data  <= '0;
        end else if (frame_start) begin
            tx_valid <= take;
            if (take) begin
                tx_rd   <= hold_rd;
                tx_addr <= hold_addr;
                tx_data <= hold_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= overrun | reject;
    end

    p_set_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pending && wr_cmd) |=> cmd_pending);

    p_clear_at_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && frame_start) |=> (!cmd_pending && tx_valid));

    p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(tx_valid) && $stable(tx_addr) && $stable(tx_data)));

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && wr_cmd && !frame_start) |=>
            (cmd_pending && overrun && $stable(hold_addr) && $stable(hold_data)));

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/codec_rsp_track.sv
module codec_rsp_track
    import codec_cmd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              take_rd,
    input  logic [ADDR_W-1:0] take_addr,
    input  logic              rx_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              stat_rd,
    output logic              stat_new,
    output logic [ADDR_W-1:0] stat_addr,
    output logic [DATA_W-1:0] stat_data
);

    rsp_state_t        state, nxt;
    logic [ADDR_W-1:0] flight_addr, due_addr;
    logic              in_flight, is_due, hit;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        in_flight = (state == RSP_INFLIGHT) || (state == RSP_DUE_INFLIGHT);
        is_due    = (state == RSP_DUE)      || (state == RSP_DUE_INFLIGHT);
        hit       = rx_valid && !frame_start && is_due && (rx_addr == due_addr);
    end

    always_comb begin
        nxt = state;
        if (frame_start) begin
            unique case ({in_flight, take_rd})
                2'b00: nxt = RSP_IDLE;
                2'b01: nxt = RSP_INFLIGHT;
                2'b10: nxt = RSP_DUE;
                2'b11: nxt = RSP_DUE_INFLIGHT;
            endcase
        end else if (hit) begin
            unique case (state)
                RSP_DUE:          nxt = RSP_IDLE;
                RSP_DUE_INFLIGHT: nxt = RSP_INFLIGHT;
                default:          nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flight_addr <= '0;
            due_addr    <= '0;
        end else if (frame_start) begin
            due_addr <= flight_addr;
            if (take_rd) flight_addr <= take_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_new  <= 1'b0;
            stat_addr <= '0;
            stat_data <= '0;
        end else if (hit) begin
            stat_new  <= 1'b1;
            stat_addr <= rx_addr;
            stat_data <= rx_data;
        end else if (stat_rd) begin
            stat_new  <= 1'b0;
        end
    end

    p_load_needs_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_new) |-> $past(is_due));

    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_new && stat_rd && !rx_valid) |=> !stat_new);

    p_boundary_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !stat_new) |=> !stat_new);

endmodule

// File: rtl/codec_cmd_ctrl.sv
module codec_cmd_ctrl
    import codec_cmd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_cmd_wr,
    input  logic              sw_cmd_rd,
    input  logic [ADDR_W-1:0] sw_cmd_addr,
    input  logic [DATA_W-1:0] sw_cmd_data,
    input  logic              sw_stat_rd,
    output logic              cmd_new,
    output logic              cmd_overrun,
    output logic              stat_new,
    output logic [ADDR_W-1:0] stat_addr,
    output logic [DATA_W-1:0] stat_data,
    input  logic              frame_start,
    output logic              tx_valid,
    output logic              tx_rd,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [DATA_W-1:0] rx_data
);

    logic              take_rd;
    logic [ADDR_W-1:0] take_addr;

    codec_cmd_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .wr_cmd      (sw_cmd_wr),
        .wr_rd       (sw_cmd_rd),
        .wr_addr     (sw_cmd_addr),
        .wr_data     (sw_cmd_data),
        .cmd_pending (cmd_new),
        .overrun     (cmd_overrun),
        .tx_valid    (tx_valid),
        .tx_rd       (tx_rd),
        .tx_addr     (tx_addr),
        .tx_data     (tx_data),
        .take_rd     (take_rd),
        .take_addr   (take_addr)
    );

    codec_rsp_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .take_rd     (take_rd),
        .take_addr   (take_addr),
        .rx_valid    (rx_valid),
        .rx_addr     (rx_addr),
        .rx_data     (rx_data),
        .stat_rd     (sw_stat_rd),
        .stat_new    (stat_new),
        .stat_addr   (stat_addr),
        .stat_data   (stat_data)
    );

    p_write_no_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_rd && frame_start && !stat_new && !rx_valid) |=> !stat_new);

endmodule

// File: tb/test_codec_cmd_ctrl.sv
module test_codec_cmd_ctrl;
    localparam int AW = 7;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sw_cmd_wr, sw_cmd_rd, sw_stat_rd;
    logic [AW-1:0] sw_cmd_addr;
    logic [DW-1:0] sw_cmd_data;
    logic          cmd_new, cmd_overrun, stat_new;
    logic [AW-1:0] stat_addr;
    logic [DW-1:0] stat_data;
    logic          frame_start, tx_valid, tx_rd, rx_valid;
    logic [AW-1:0] tx_addr, rx_addr;
    logic [DW-1:0] tx_data, rx_data;

    always #5 clk = ~clk;

    codec_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_codec_cmd_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sw_cmd_wr(sw_cmd_wr), .sw_cmd_rd(sw_cmd_rd), .sw_cmd_addr(sw_cmd_addr),
        .sw_cmd_data(sw_cmd_data), .sw_stat_rd(sw_stat_rd),
        .cmd_new(cmd_new), .cmd_overrun(cmd_overrun), .stat_new(stat_new),
        .stat_addr(stat_addr), .stat_data(stat_data),
        .frame_start(frame_start), .tx_valid(tx_valid), .tx_rd(tx_rd),
        .tx_addr(tx_addr), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_addr(rx_addr), .rx_data(rx_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0]    exp_mem   [0:(1<<AW)-1];
    logic [DW-1:0]    codec_mem [0:(1<<AW)-1];
    logic [AW+DW-1:0] sb_q [$];

    bit mon_en        = 1;
    bit boundary_mode = 0;
    bit corrupt_mode  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // codec model: answers a read in the frame after the one that carried it
    initial begin
        logic          pend_v, due_v;
        logic [AW-1:0] pend_a, due_a;
        pend_v = 0; pend_a = '0; due_v = 0; due_a = '0;
        frame_start = 0; rx_valid = 0; rx_addr = '0; rx_data = '0;
        for (int i = 0; i < (1<<AW); i++) codec_mem[i] = 16'hA000 ^ DW'(i);
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            frame_start = 1;
            due_v = pend_v; due_a = pend_a; pend_v = 0;
            if (due_v && boundary_mode) begin
                rx_valid = 1; rx_addr = due_a; rx_data = codec_mem[due_a];
            end
            @(negedge clk);
            frame_start = 0; rx_valid = 0;
            if (tx_valid) begin
                if (tx_rd) begin pend_v = 1; pend_a = tx_addr; end
                else codec_mem[tx_addr] = tx_data;
            end
            repeat (2) @(negedge clk);
            if (due_v && !boundary_mode) begin
                rx_valid = 1;
                rx_addr  = corrupt_mode ? (due_a ^ AW'(1)) : due_a;
                rx_data  = codec_mem[due_a];
            end
            @(negedge clk);
            rx_valid = 0;
            repeat (3) @(negedge clk);
        end
    end

    // monitor: pops the scoreboard whenever status data appears
    initial begin
        sw_stat_rd = 0;
        forever begin
            @(negedge clk);
            if (mon_en && rst_n) begin
                if (sw_stat_rd) begin
                    sw_stat_rd = 0;
                    chk("R8 stat_new cleared by read", 32'(stat_new), 32'd0);
                end else if (stat_new) begin
                    if (sb_q.size() == 0) begin
                        chk("R4/R6 unexpected stat_new", 32'(stat_new), 32'd0);
                    end else begin
                        logic [AW+DW-1:0] e;
                        e = sb_q.pop_front();
                        chk("R5 stat_addr", 32'(stat_addr), 32'(e[AW+DW-1:DW]));
                        chk("R5 stat_data", 32'(stat_data), 32'(e[DW-1:0]));
                    end
                    sw_stat_rd = 1;
                end
            end
        end
    end

    task automatic raw_cmd(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
        sw_cmd_wr = 1; sw_cmd_rd = rd; sw_cmd_addr = a; sw_cmd_data = d;
        @(negedge clk);
        sw_cmd_wr = 0;
    endtask

    // driver: posts a command, checks pickup, records the expected result
    task automatic issue(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit expect_rsp);
        while (cmd_new) @(negedge clk);
        raw_cmd(rd, a, d);
        chk("R2 cmd_new set after post", 32'(cmd_new), 32'd1);
        while (cmd_new) @(negedge clk);
        chk("R3 tx_valid at pickup", 32'(tx_valid), 32'd1);
        chk("R3 tx_rd", 32'(tx_rd), 32'(rd));
        chk("R3 tx_addr", 32'(tx_addr), 32'(a));
        if (!rd) begin
            chk("R3 tx_data", 32'(tx_data), 32'(d));
            exp_mem[a] = d;
        end else if (expect_rsp) begin
            sb_q.push_back({a, exp_mem[a]});
        end
    endtask

    task automatic drain();
        while (sb_q.size() != 0 || cmd_new) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1<<AW); i++) exp_mem[i] = 16'hA000 ^ DW'(i);
        rst_n = 0; sw_cmd_wr = 0; sw_cmd_rd = 0; sw_cmd_addr = '0; sw_cmd_data = '0;
        repeat (4) @(negedge clk);
        chk("R1 cmd_new reset", 32'(cmd_new), 32'd0);
        chk("R1 overrun reset", 32'(cmd_overrun), 32'd0);
        chk("R1 stat_new reset", 32'(stat_new), 32'd0);
        chk("R1 tx_valid reset", 32'(tx_valid), 32'd0);
        rst_n = 1;

        // R4: writes, including boundary addresses; no status may appear
        issue(0, 7'h00, 16'h1234, 0);
        issue(0, 7'h7F, 16'hBEEF, 0);
        issue(0, 7'h2A, 16'h5A5A, 0);
        drain();
        chk("R4 no status after writes", 32'(stat_new), 32'd0);

        // R5: single reads, written and untouched registers
        issue(1, 7'h2A, '0, 1);
        drain();
        issue(1, 7'h7F, '0, 1);
        drain();
        issue(1, 7'h11, '0, 1);
        drain();

        // R7: second read queued while first result outstanding
        issue(1, 7'h00, '0, 1);
        chk("R7 stat_new still 0 after cmd_new clears", 32'(stat_new), 32'd0);
        issue(1, 7'h7F, '0, 1);
        issue(0, 7'h33, 16'hC0DE, 0);
        issue(1, 7'h33, '0, 1);
        drain();

        // R6: returned address mismatch is ignored
        corrupt_mode = 1;
        issue(1, 7'h10, '0, 0);
        repeat (24) @(negedge clk);
        chk("R6 mismatch ignored", 32'(stat_new), 32'd0);
        corrupt_mode = 0;

        // R10: answer on a frame_start cycle is ignored
        boundary_mode = 1;
        issue(1, 7'h12, '0, 0);
        repeat (24) @(negedge clk);
        chk("R10 boundary answer ignored", 32'(stat_new), 32'd0);
        boundary_mode = 0;
        drain();

        // R9: command posted while pending is dropped, overrun sticks
        wait (frame_start === 1'b1);
        @(negedge clk);
        raw_cmd(0, 7'h05, 16'h1111);
        raw_cmd(0, 7'h06, 16'h2222);
        chk("R9 overrun set", 32'(cmd_overrun), 32'd1);
        while (cmd_new) @(negedge clk);
        chk("R9 first command sent addr", 32'(tx_addr), 32'h05);
        chk("R9 first command sent data", 32'(tx_data), 32'h1111);
        exp_mem[7'h05] = 16'h1111;
        issue(1, 7'h06, '0, 1);
        drain();
        issue(1, 7'h05, '0, 1);
        drain();
        chk("R9 overrun sticky", 32'(cmd_overrun), 32'd1);

        // R8: status read in the same cycle as a new matching answer
        mon_en = 0;
        issue(1, 7'h20, '0, 0);
        while (!stat_new) @(negedge clk);
        chk("R8 first data", 32'(stat_data), 32'(exp_mem[7'h20]));
        issue(1, 7'h21, '0, 0);
        @(posedge rx_valid);
        sw_stat_rd = 1;
        @(negedge clk);
        sw_stat_rd = 0;
        chk("R8 load wins stat_new", 32'(stat_new), 32'd1);
        chk("R8 load wins data", 32'(stat_data), 32'(exp_mem[7'h21]));
        sw_stat_rd = 1;
        @(negedge clk);
        sw_stat_rd = 0;
        chk("R8 clear", 32'(stat_new), 32'd0);
        mon_en = 1;

        repeat (10) @(negedge clk);
        chk("R5 scoreboard empty", 32'(sb_q.size()), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule